// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block runs on the host side of a parallel NOR flash. It decides whether a program or erase operation that was started earlier has finished. A one-cycle `start` launches a check. The block then reads the flash status byte through a simple bus port that uses a request/acknowledge handshake. It compares the toggle bit across consecutive reads and, when needed, consults the timeout flag of the same byte. It ends the check with a single-cycle `done` or `fail` pulse. On every failure it first writes the flash reset command, so that the device returns to array reads.

A rising timeout flag does not cause an immediate failure. Toggling may stop in the same read in which the timeout flag rises, so the block makes one extra pair of reads before it decides. A programmable limit on the number of ordinary read pairs stops a device that never settles. The host may abandon a check with `abort` and later issue a new `start`. The new check always begins again with a fresh pair of reads.

Top module: `flash_poll_ctrl`

## Requirements
- R1: A `start` while idle raises `busy` on the next cycle and begins a check; a `start` while `busy` is high is ignored and adds no bus access.
- R2: Every check and every repeat begins with a pair of reads from `status_addr`. The toggle bit (bit `TOG_BIT`, default 6) of the first read is stored and compared with the same bit of the second read.
- R3: If the two toggle bits match, the block pulses `done` and makes no further bus access.
- R4: If they differ and the timeout flag (bit `TMO_BIT`, default 5) of the second read is 0, the block starts a new read pair and stores a fresh reference from that pair's first read. The timeout flag of the first read of a pair is never consulted.
- R5: If they differ and the timeout flag of the second read is 1, exactly one more read pair is made. If its toggle bits match, `done` is pulsed.
- R6: If the extra pair of R5 still toggles, the block writes `RESET_CMD` (default 0xF0) to `status_addr`. It pulses `fail` only after that write is acknowledged.
- R7: If `max_pairs` ordinary pairs have all toggled with a 0 timeout flag, the block takes the failure path of R6. A `max_pairs` of 0 behaves as 1.
- R8: `done` and `fail` last one cycle, never occur together, and `busy` is low in the cycle in which either is high.
- R9: `abort` during a check drops any pending read, clears `busy` on the next cycle and produces no `done` or `fail`. It is ignored while the reset command is being written. The next `start` begins again at R2.
- R10: `bus_req` stays high, with `bus_we`, `bus_addr` and `bus_wdata` unchanged, until `bus_ack`; read data is taken in the cycle `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a completion check |
| abort | input | 1 | Abandon the check in progress |
| status_addr | input | AW | Address used for status reads and the reset write |
| max_pairs | input | CW | Ordinary read pairs allowed before giving up |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Access acknowledge |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |
| busy | output | 1 | Check in progress |
| done | output | 1 | Operation finished (one-cycle pulse) |
| fail | output | 1 | Operation failed (one-cycle pulse) |

## Verification
The assertions check the following on every cycle:
- the pulse shape of `done` and `fail`, and that they exclude each other;
- that `busy` falls together with either pulse;
- that the bus stays silent while idle and that a request holds its fields until acknowledged;
- that the only write ever issued carries the reset command, and that `fail` is always preceded by that write.

The read-pair decisions themselves appear only in the bench scenarios, which count reads and writes per check:
- which timeout flag is consulted;
- that the reference value is taken fresh for each pair;
- the extra re-check pair;
- the pair limit;
- a resumed check after an abort.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAIR_A,
    ST_PAIR_B,
    ST_CHK_A,
    ST_CHK_B,
    ST_RESET
  } poll_state_t;

endpackage

// File: rtl/flash_bus_port.sv
module flash_bus_port #(
  parameter int AW = 24,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  input  logic          cancel,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          fin,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      fin       <= 1'b0;
      rdata     <= '0;
    end else begin
      fin <= 1'b0;
      if (cancel) begin
        bus_req <= 1'b0;
      end else if (bus_req && bus_ack) begin
        bus_req <= 1'b0;
        fin     <= 1'b1;
        rdata   <= bus_rdata;
      end else if (go && !bus_req) begin
        bus_req   <= 1'b1;
        bus_we    <= go_we;
        bus_addr  <= go_addr;
        bus_wdata <= go_wdata;
      end
    end
  end

endmodule

// File: rtl/flash_toggle_cmp.sv
module flash_toggle_cmp #(
  parameter int DW      = 8,
  parameter int TOG_BIT = 6,
  parameter int TMO_BIT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          capture,
  input  logic [DW-1:0] sample,
  output logic          toggled,
  output logic          timed_out,
  output logic          ref_ok
);

  logic ref_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_bit <= 1'b0;
      ref_ok  <= 1'b0;
    end else if (clear) begin
      ref_ok  <= 1'b0;
    end else if (capture) begin
      ref_bit <= sample[TOG_BIT];
      ref_ok  <= 1'b1;
    end
  end

  // a missing reference is treated as still toggling
  assign toggled   = !ref_ok || (sample[TOG_BIT] != ref_bit);
  assign timed_out = sample[TMO_BIT];

endmodule

// File: rtl/flash_poll_limit.sv
module flash_poll_limit #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic [CW-1:0] max_pairs,
  output logic          last
);

  logic [CW-1:0] cnt;
  logic [CW:0]   nxt;

  assign nxt  = {1'b0, cnt} + 1'b1;
  assign last = nxt >= {1'b0, max_pairs};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (step && !(&cnt)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int            AW        = 24,
  parameter int            DW        = 8,
  parameter int            CW        = 8,
  parameter int            TOG_BIT   = 6,
  parameter int            TMO_BIT   = 5,
  parameter logic [DW-1:0] RESET_CMD = 8'hF0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic [AW-1:0] status_addr,
  input  logic [CW-1:0] max_pairs,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail
);

  poll_state_t   state;
  logic          pend;
  logic          go, go_we, fin;
  logic [DW-1:0] rdata;
  logic          toggled, timed_out, ref_ok;
  logic          last_pair;
  logic          cmd_phase, abort_eff, launch;
  logic          capture, step;

  assign cmd_phase = (state == ST_RESET);
  assign abort_eff = abort && (state != ST_IDLE) && !cmd_phase;
  assign launch    = (state == ST_IDLE) && start;
  assign go        = !pend && (state != ST_IDLE) && !abort_eff;
  assign go_we     = cmd_phase;
  assign capture   = fin && ((state == ST_PAIR_A) || (state == ST_CHK_A));
  assign step      = fin && (state == ST_PAIR_B) && toggled && !timed_out && ref_ok;

  flash_bus_port #(.AW(AW), .DW(DW)) u_port (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .go_we     (go_we),
    .go_addr   (status_addr),
    .go_wdata  (RESET_CMD),
    .cancel    (abort_eff),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .fin       (fin),
    .rdata     (rdata)
  );

  flash_toggle_cmp #(.DW(DW), .TOG_BIT(TOG_BIT), .TMO_BIT(TMO_BIT)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .clear     (launch || abort_eff),
    .capture   (capture),
    .sample    (rdata),
    .toggled   (toggled),
    .timed_out (timed_out),
    .ref_ok    (ref_ok)
  );

  flash_poll_limit #(.CW(CW)) u_limit (
    .clk       (clk),
    .rst       (rst),
    .clear     (launch),
    .step      (step),
    .max_pairs (max_pairs),
    .last      (last_pair)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pend  <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      if (abort_eff) begin
        state <= ST_IDLE;
        pend  <= 1'b0;
        busy  <= 1'b0;
      end else if (state == ST_IDLE) begin
        pend <= 1'b0;
        if (start) begin
          state <= ST_PAIR_A;
          busy  <= 1'b1;
        end
      end else begin
        if (go) pend <= 1'b1;
        if (fin) begin
          pend <= 1'b0;
          case (state)
            ST_PAIR_A: state <= ST_PAIR_B;
            ST_PAIR_B: begin
              if (!toggled) begin
                done  <= 1'b1;
                busy  <= 1'b0;
                state <= ST_IDLE;
              end else if (timed_out) begin
                state <= ST_CHK_A;
              end else if (last_pair) begin
                state <= ST_RESET;
              end else begin
                state <= ST_PAIR_A;
              end
            end
            ST_CHK_A: state <= ST_CHK_B;
            ST_CHK_B: begin
              if (!toggled) begin
                done  <= 1'b1;
                busy  <= 1'b0;
                state <= ST_IDLE;
              end else begin
                state <= ST_RESET;
              end
            end
            ST_RESET: begin
              fail  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/flash_poll_ctrl_chk.sv
module flash_poll_ctrl_chk #(
  parameter int            AW        = 24,
  parameter int            DW        = 8,
  parameter logic [DW-1:0] RESET_CMD = 8'hF0
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          abort,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ack,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          cmd_phase
);

  logic wrote_cmd;

  always_ff @(posedge clk) begin
    if (rst) wrote_cmd <= 1'b0;
    else if (start && !busy) wrote_cmd <= 1'b0;
    else if (bus_req && bus_we && bus_ack) wrote_cmd <= 1'b1;
  end

  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_fail_pulse: assert property (@(posedge clk) disable iff (rst)
    fail |=> !fail);
  a_r8_busy_drop: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> (!busy && $past(busy)));
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack && !abort) |=>
      (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req);
  a_r6_cmd_value: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we) |-> (bus_wdata == RESET_CMD));
  a_r6_fail_after_write: assert property (@(posedge clk) disable iff (rst)
    fail |-> wrote_cmd);
  a_r9_abort_stops: assert property (@(posedge clk) disable iff (rst)
    (abort && busy && !cmd_phase) |=> (!busy && !done && !fail && !bus_req));

endmodule

bind flash_poll_ctrl flash_poll_ctrl_chk #(
  .AW(AW), .DW(DW), .RESET_CMD(RESET_CMD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .abort     (abort),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .cmd_phase (cmd_phase)
);

// File: tb/flash_poll_ctrl_test.sv
module flash_poll_ctrl_test;

  localparam int AW = 24;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int NV = 8;

  // status bytes: bit6 = toggle, bit5 = timeout flag
  localparam logic [7:0] TA  = 8'h40;
  localparam logic [7:0] TB  = 8'h00;
  localparam logic [7:0] TA5 = 8'h60;
  localparam logic [7:0] TB5 = 8'h20;

  localparam logic [7:0] V_RD [0:NV-1][0:5] = '{
    '{TA,  TA,  TB,  TB,  TB,  TB},   // R3 settled at once
    '{TA,  TB,  TB,  TB,  TB,  TB},   // R4 fresh reference per pair
    '{TA,  TB5, TA5, TA5, TB,  TB},   // R5 re-check settles
    '{TA,  TB5, TA5, TB5, TB,  TB},   // R6 re-check still toggling
    '{TA,  TB,  TA,  TB,  TB,  TB},   // R7 limit of two pairs
    '{TA,  TB,  TB,  TB,  TB,  TB},   // R7 limit zero acts as one
    '{TA,  TB,  TB,  TA,  TA,  TA},   // R4 third pair settles
    '{TA5, TB,  TA,  TB,  TB,  TB}    // R4 flag of first read ignored
  };
  localparam int V_MAX  [0:NV-1] = '{4, 4, 4, 4, 2, 0, 4, 4};
  localparam bit V_DONE [0:NV-1] = '{1, 1, 1, 0, 0, 0, 1, 1};
  localparam int V_NRD  [0:NV-1] = '{2, 4, 4, 4, 4, 2, 6, 6};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          abort = 1'b0;
  logic [AW-1:0] status_addr = 24'h00_0AAA;
  logic [CW-1:0] max_pairs = 8'd4;
  logic          bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ack;
  logic [DW-1:0] bus_rdata;
  logic          busy, done, fail;

  logic [7:0] script [0:5];
  logic       clr_model = 1'b0;
  int         rd_cnt, wr_cnt, idx;
  logic [7:0] last_wdata;
  logic [AW-1:0] last_addr;

  int total = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_poll_ctrl #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .status_addr(status_addr), .max_pairs(max_pairs),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .fail(fail)
  );

  // flash model: acknowledges one cycle after a request is seen
  always @(posedge clk) begin
    if (rst || clr_model) begin
      bus_ack    <= 1'b0;
      bus_rdata  <= '0;
      rd_cnt     <= 0;
      wr_cnt     <= 0;
      idx        <= 0;
      last_wdata <= '0;
      last_addr  <= '0;
    end else if (bus_req && !bus_ack) begin
      bus_ack   <= 1'b1;
      last_addr <= bus_addr;
      if (bus_we) begin
        wr_cnt     <= wr_cnt + 1;
        last_wdata <= bus_wdata;
      end else begin
        rd_cnt    <= rd_cnt + 1;
        bus_rdata <= (idx < 6) ? script[idx] : 8'h00;
        idx       <= idx + 1;
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load(input int v);
    for (int i = 0; i < 6; i++) script[i] = V_RD[v][i];
    @(negedge clk); clr_model = 1'b1;
    @(negedge clk); clr_model = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // waits for done or fail; returns 1 = done, 0 = fail, -1 = timeout
  task automatic wait_end(output int res);
    res = -1;
    for (int c = 0; c < 300; c++) begin
      if (done || fail) begin
        res = done ? 1 : 0;
        chk(!busy, "R8 busy low with pulse", busy, 0);
        chk(!(done && fail), "R8 exclusive", done & fail, 0);
        @(negedge clk);
        chk(!done && !fail, "R8 single-cycle pulse", done | fail, 0);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input int v);
    int res;
    load(v);
    max_pairs = V_MAX[v][CW-1:0];
    pulse_start();
    chk(busy, "R1 busy after start", busy, 1);
    wait_end(res);
    chk(res == (V_DONE[v] ? 1 : 0), $sformatf("R3/R5/R6 outcome vec %0d", v), res, V_DONE[v] ? 1 : 0);
    repeat (4) @(negedge clk);
    chk(rd_cnt == V_NRD[v], $sformatf("R2/R4/R7 read count vec %0d", v), rd_cnt, V_NRD[v]);
    chk(wr_cnt == (V_DONE[v] ? 0 : 1), $sformatf("R6 write count vec %0d", v), wr_cnt, V_DONE[v] ? 0 : 1);
    if (!V_DONE[v]) begin
      chk(last_wdata == 8'hF0, "R6 reset command value", last_wdata, 8'hF0);
      chk(last_addr == status_addr, "R6 reset command address", last_addr, status_addr);
    end
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - errors, total);
    $finish;
  end

  initial begin
    int res;
    for (int i = 0; i < 6; i++) script[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fail && !bus_req, "R1 reset state",
        {busy, done, fail, bus_req}, 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R1: start while busy is ignored
    load(1);
    max_pairs = 8'd4;
    pulse_start();
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end(res);
    chk(res == 1, "R1 outcome with second start", res, 1);
    repeat (10) @(negedge clk);
    chk(rd_cnt == 4, "R1 second start adds no reads", rd_cnt, 4);

    // R9: abort mid-check, then restart from a fresh pair
    load(4);
    max_pairs = 8'd100;
    pulse_start();
    repeat (5) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk(!busy, "R9 busy cleared by abort", busy, 1'b0);
    res = -1;
    for (int c = 0; c < 30; c++) begin
      if (done || fail || bus_req) res = 1;
      @(negedge clk);
    end
    chk(res == -1, "R9 no pulse or access after abort", res, -1);
    load(0);
    max_pairs = 8'd4;
    pulse_start();
    wait_end(res);
    chk(res == 1, "R9 resumed check settles", res, 1);
    repeat (4) @(negedge clk);
    chk(rd_cnt == 2, "R9 resumed check reads a fresh pair", rd_cnt, 2);

    // R9: abort during the reset write is ignored
    load(5);
    max_pairs = 8'd0;
    pulse_start();
    for (int c = 0; c < 100; c++) begin
      if (bus_req && bus_we) break;
      @(negedge clk);
    end
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    wait_end(res);
    chk(res == 0, "R9 abort ignored in reset write", res, 0);
    repeat (4) @(negedge clk);
    chk(wr_cnt == 1, "R9 reset write completed", wr_cnt, 1);

    $display("%0d/%0d checks passed", total - errors, total);
    $finish;
  end

endmodule